// File: doc/BRIEF.md
# Tiled Integer Multiply-Accumulate Engine

This block holds three square tiles of a larger matrix in on-chip storage and updates the accumulator tile in place with the product of the two operand tiles, C := C + A·B. A tile is 32 by 32 elements. Operand elements are 16-bit signed, and accumulator elements are 32-bit. A host fills the tiles through a write port, pulses `start`, waits for `done`, and then reads the accumulator tile back. Because the update adds into C, a host that works through a larger product can hold one output tile resident. It then runs the engine once per inner tile index with fresh A and B tiles, and reads C only at the end.

Inside, the 1024 output positions are issued one per clock, with the row index outer and the column index inner. Each issued position needs a full row of A and a full column of B in the same cycle. The A tile is therefore interleaved element by element across 16 two-port banks. The B tile is cut into 16 contiguous 64-element slabs, one per two-port bank. Thirty-two multipliers feed a fully registered binary adder tree. The old C value travels alongside the sum and is added at write-back.

The load port and the read-request port are valid/ready streams. A beat transfers on a clock edge where both valid and ready are high. Both ready signals are low for the whole of a run, so the host must hold its beat until ready returns. The read response has no back-pressure: it appears exactly one cycle after the request transfers and holds for that cycle only. `start`, `busy` and `done` are plain control pins.

Top module: `mxm_tile_engine`

## Requirements
- R1: After reset, `busy`, `done` and `rd_rsp_valid` are low, and `ld_ready` and `rd_ready` are high.
- R2: Tiles are stored row-major: load or read address r*32+c is row r, column c of the selected tile.
- R3: A run replaces each C[i][j] with C[i][j] plus the sum over k of A[i][k]*B[k][j]. The arithmetic is 32-bit two's complement and wraps on overflow.
- R4: While `busy` is high, `ld_ready` is low and load beats presented on the port change no tile.
- R5: A `start` pulse while `busy` is high is ignored. It neither restarts the run nor queues a second one.
- R6: `done` rises exactly TILE*TILE+7 (1031) clock edges after the edge that samples `start` while idle.
- R7: `done` is a single-cycle pulse, and `busy` is already low in that cycle.
- R8: A read request transfers only while `rd_ready` is high, which it is exactly when not busy. `rd_rsp_valid` and `rd_rsp_data` follow one cycle later, carrying the C element at that address.
- R9: Successive runs without reloading C accumulate into the same C tile.
- R10: `ld_sel` encodes 0 = A, 1 = B, 2 = C. A beat with `ld_sel` = 3 changes no tile.
- R11: For A and B loads, only `ld_data[15:0]` is used, as a signed value. Bits 31:16 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid | input | 1 | Load beat valid |
| ld_ready | output | 1 | Load beat accepted when high (idle) |
| ld_sel | input | 2 | Target tile: 0 A, 1 B, 2 C, 3 none |
| ld_addr | input | 10 | Flat element index r*32+c |
| ld_data | input | 32 | Element value (A/B use bits 15:0) |
| rd_valid | input | 1 | C read request valid |
| rd_ready | output | 1 | Read request accepted when high (idle) |
| rd_addr | input | 10 | Flat C element index |
| rd_rsp_valid | output | 1 | Read response valid, one cycle after request |
| rd_rsp_data | output | 32 | C element value |
| start | input | 1 | Begin a run when idle |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse at the end of a run |

## Verification
A wrong bank mapping for A or B corrupts only the outputs whose operands come from that bank, so a full readback after random tiles shows a structured pattern of bad elements. A misaligned tag in the adder pipeline makes every element carry a neighbour's old C value, which is visible on the first readback. A sequencer fault that drops or repeats a position, or miscounts the drain, moves `done` away from edge 1031, which is caught within one run. The extreme-value tile is a directed case that exposes width or sign errors through the wrapped sum.

// File: rtl/mxm_pkg.sv
package mxm_pkg;
  typedef enum logic [1:0] {
    SEL_A    = 2'd0,
    SEL_B    = 2'd1,
    SEL_C    = 2'd2,
    SEL_NONE = 2'd3
  } tile_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_DRAIN = 2'd2
  } seq_state_e;
endpackage

// File: rtl/mxm_bank.sv
// One storage bank with a single write port and two registered read ports.
module mxm_bank #(
  parameter int W     = 16,
  parameter int DEPTH = 64,
  localparam int AW_B = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            we,
  input  logic [AW_B-1:0] waddr,
  input  logic [W-1:0]    wdata,
  input  logic [AW_B-1:0] raddr0,
  input  logic [AW_B-1:0] raddr1,
  output logic [W-1:0]    rdata0,
  output logic [W-1:0]    rdata1
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata0 <= mem[raddr0];
    rdata1 <= mem[raddr1];
  end
endmodule

// File: rtl/mxm_dot.sv
// Fully unrolled dot product: registered products, then a registered binary
// tree. Latency is 1 + log2(TILE). A tag travels alongside the data.
module mxm_dot #(
  parameter int TILE  = 32,
  parameter int EW    = 16,
  parameter int AW    = 32,
  parameter int TAG_W = 42,
  localparam int LOG_T   = $clog2(TILE),
  localparam int DOT_LAT = 1 + LOG_T
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_v,
  input  logic [TAG_W-1:0]   in_tag,
  input  logic [TILE*EW-1:0] a_vec,
  input  logic [TILE*EW-1:0] b_vec,
  output logic               out_v,
  output logic [TAG_W-1:0]   out_tag,
  output logic [AW-1:0]      out_sum
);
  logic signed [AW-1:0] prod [TILE];
  // heap-ordered tree: node 1 is the root, leaves at TILE..2*TILE-1
  logic [AW-1:0] node [1:2*TILE-1];
  logic [DOT_LAT-1:0] v_pipe;
  logic [TAG_W-1:0]   tag_pipe [DOT_LAT];

  genvar k;
  generate
    for (k = 0; k < TILE; k++) begin : g_mul
      logic signed [AW-1:0] ax, bx;
      assign ax = {{(AW-EW){a_vec[k*EW+EW-1]}}, a_vec[k*EW +: EW]};
      assign bx = {{(AW-EW){b_vec[k*EW+EW-1]}}, b_vec[k*EW +: EW]};
      assign prod[k] = ax * bx;
    end
  endgenerate

  always_ff @(posedge clk) begin
    for (int n = 0; n < TILE; n++) node[TILE+n] <= prod[n];
    for (int n = 1; n < TILE; n++) node[n] <= node[2*n] + node[2*n+1];
    tag_pipe[0] <= in_tag;
    for (int s = 1; s < DOT_LAT; s++) tag_pipe[s] <= tag_pipe[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_pipe <= '0;
    else        v_pipe <= {v_pipe[DOT_LAT-2:0], in_v};
  end

  assign out_v   = v_pipe[DOT_LAT-1];
  assign out_tag = tag_pipe[DOT_LAT-1];
  assign out_sum = node[1];
endmodule

// File: rtl/mxm_seq.sv
// Issues output positions one per clock, then waits for the last write-back.
module mxm_seq
  import mxm_pkg::*;
#(
  parameter int ELEMS = 1024,
  localparam int IDX_W = $clog2(ELEMS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             wb_v,
  input  logic [IDX_W-1:0] wb_pos,
  output logic             busy,
  output logic             done,
  output logic             iss_v,
  output logic [IDX_W-1:0] iss_pos
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ELEMS - 1);

  seq_state_e state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      iss_pos <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          state   <= ST_ISSUE;
          iss_pos <= '0;
        end
        ST_ISSUE: begin
          iss_pos <= iss_pos + 1'b1;
          if (iss_pos == LAST) state <= ST_DRAIN;
        end
        ST_DRAIN: if (wb_v && wb_pos == LAST) begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy  = (state != ST_IDLE);
  assign iss_v = (state == ST_ISSUE);

  // R3: positions leave the sequencer in strict row-major order
  p_issue_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_v && $past(iss_v)) |-> (iss_pos == $past(iss_pos) + 1'b1));
  // R6: done follows the write-back of the final position
  p_done_after_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(wb_v) && $past(wb_pos) == LAST));
  // R7: single-cycle pulse
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/mxm_tile_engine.sv
module mxm_tile_engine
  import mxm_pkg::*;
#(
  parameter int TILE = 32,
  parameter int EW   = 16,
  parameter int AW   = 32,
  localparam int ELEMS = TILE * TILE,
  localparam int IDX_W = $clog2(ELEMS),
  localparam int LOG_T = $clog2(TILE),
  localparam int NBANK = TILE / 2,
  localparam int NB_W  = $clog2(NBANK),
  localparam int BDEP  = ELEMS / NBANK,
  localparam int BA_W  = $clog2(BDEP),
  localparam int TAG_W = IDX_W + AW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_valid,
  output logic             ld_ready,
  input  logic [1:0]       ld_sel,
  input  logic [IDX_W-1:0] ld_addr,
  input  logic [AW-1:0]    ld_data,
  input  logic             rd_valid,
  output logic             rd_ready,
  input  logic [IDX_W-1:0] rd_addr,
  output logic             rd_rsp_valid,
  output logic [AW-1:0]    rd_rsp_data,
  input  logic             start,
  output logic             busy,
  output logic             done
);
  logic             ld_acc;
  logic             iss_v, s1_v, wb_v;
  logic [IDX_W-1:0] iss_pos, s1_pos, wb_pos;
  logic [LOG_T-1:0] row_i, col_j;
  logic [TILE*EW-1:0] a_vec, b_vec;
  logic [TAG_W-1:0] wb_tag;
  logic [AW-1:0]    wb_sum, c_old_wb, wb_val, c_rd_q;
  logic [AW-1:0]    c_mem [ELEMS];

  assign ld_ready = !busy;
  assign rd_ready = !busy;
  assign ld_acc   = ld_valid && ld_ready;
  assign row_i    = iss_pos[IDX_W-1:LOG_T];
  assign col_j    = iss_pos[LOG_T-1:0];

  mxm_seq #(.ELEMS(ELEMS)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .wb_v(wb_v), .wb_pos(wb_pos),
    .busy(busy), .done(done), .iss_v(iss_v), .iss_pos(iss_pos)
  );

  // A: element index e lives in bank e mod NBANK at word e / NBANK.
  // Row i, column k -> bank k mod NBANK, word 2i + k / NBANK.
  genvar m;
  generate
    for (m = 0; m < NBANK; m++) begin : g_abank
      logic          we;
      logic [EW-1:0] rd0, rd1;
      assign we = ld_acc && (ld_sel == SEL_A) && (ld_addr[NB_W-1:0] == NB_W'(m));
      mxm_bank #(.W(EW), .DEPTH(BDEP)) u_bank (
        .clk(clk), .we(we), .waddr(ld_addr[IDX_W-1:NB_W]), .wdata(ld_data[EW-1:0]),
        .raddr0({row_i, 1'b0}), .raddr1({row_i, 1'b1}),
        .rdata0(rd0), .rdata1(rd1)
      );
      assign a_vec[m*EW +: EW]         = rd0;
      assign a_vec[(m+NBANK)*EW +: EW] = rd1;
    end

    // B: element index e lives in bank e / BDEP at word e mod BDEP.
    // Row k, column j -> bank k/2, word (k mod 2)*TILE + j.
    for (m = 0; m < NBANK; m++) begin : g_bbank
      logic          we;
      logic [EW-1:0] rd0, rd1;
      assign we = ld_acc && (ld_sel == SEL_B) && (ld_addr[IDX_W-1:BA_W] == (IDX_W-BA_W)'(m));
      mxm_bank #(.W(EW), .DEPTH(BDEP)) u_bank (
        .clk(clk), .we(we), .waddr(ld_addr[BA_W-1:0]), .wdata(ld_data[EW-1:0]),
        .raddr0({1'b0, col_j}), .raddr1({1'b1, col_j}),
        .rdata0(rd0), .rdata1(rd1)
      );
      assign b_vec[(2*m)*EW +: EW]   = rd0;
      assign b_vec[(2*m+1)*EW +: EW] = rd1;
    end
  endgenerate

  // C: one read port shared by issue (busy) and host readback (idle),
  // one write port shared by write-back (busy) and host load (idle).
  always_ff @(posedge clk) begin
    c_rd_q <= c_mem[busy ? iss_pos : rd_addr];
    if (wb_v)
      c_mem[wb_pos] <= wb_val;
    else if (ld_acc && ld_sel == SEL_C)
      c_mem[ld_addr] <= ld_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v         <= 1'b0;
      s1_pos       <= '0;
      rd_rsp_valid <= 1'b0;
    end else begin
      s1_v         <= iss_v;
      s1_pos       <= iss_pos;
      rd_rsp_valid <= rd_valid && rd_ready;
    end
  end

  assign rd_rsp_data = c_rd_q;

  mxm_dot #(.TILE(TILE), .EW(EW), .AW(AW), .TAG_W(TAG_W)) u_dot (
    .clk(clk), .rst_n(rst_n), .in_v(s1_v), .in_tag({s1_pos, c_rd_q}),
    .a_vec(a_vec), .b_vec(b_vec),
    .out_v(wb_v), .out_tag(wb_tag), .out_sum(wb_sum)
  );

  assign wb_pos   = wb_tag[TAG_W-1:AW];
  assign c_old_wb = wb_tag[AW-1:0];
  assign wb_val   = c_old_wb + wb_sum;

  // R4: results are written only during a run
  p_wb_in_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wb_v |-> busy);
  // R8: an accepted read request is answered on the next cycle
  p_rsp_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready) |=> rd_rsp_valid);
  // R7: the run has ended when done is seen
  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

// File: tb/tb_mxm_tile_engine.sv
module tb_mxm_tile_engine;
  localparam int N  = 32;
  localparam int NE = N * N;
  localparam int EXP_LAT = NE + 7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_valid = 1'b0;
  logic        ld_ready;
  logic [1:0]  ld_sel = 2'd0;
  logic [9:0]  ld_addr = '0;
  logic [31:0] ld_data = '0;
  logic        rd_valid = 1'b0;
  logic        rd_ready;
  logic [9:0]  rd_addr = '0;
  logic        rd_rsp_valid;
  logic [31:0] rd_rsp_data;
  logic        start = 1'b0;
  logic        busy, done;

  int total = 0;
  int bad = 0;

  logic signed [15:0] ma [NE];
  logic signed [15:0] mb [NE];
  logic [31:0]        mc [NE];

  always #5 clk = ~clk;

  mxm_tile_engine dut (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_sel(ld_sel), .ld_addr(ld_addr), .ld_data(ld_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
    .start(start), .busy(busy), .done(done)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pack_elem(input logic [1:0] sel, input int idx);
    if (sel == 2'd0) return {16'($urandom), ma[idx]};
    if (sel == 2'd1) return {16'($urandom), mb[idx]};
    return mc[idx];
  endfunction

  task automatic load_tile(input logic [1:0] sel);
    int nr = 0;
    for (int idx = 0; idx < NE; idx++) begin
      @(negedge clk);
      if (!ld_ready) nr++;
      ld_valid = 1'b1; ld_sel = sel; ld_addr = 10'(idx); ld_data = pack_elem(sel, idx);
    end
    @(negedge clk);
    ld_valid = 1'b0;
    check("R4 ld_ready while idle", 32'(nr), 32'd0);
  endtask

  task automatic model_mac();
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        logic [31:0] acc = mc[i*N+j];
        for (int k = 0; k < N; k++) acc += 32'(int'(ma[i*N+k]) * int'(mb[k*N+j]));
        mc[i*N+j] = acc;
      end
  endtask

  task automatic read_all(input string req);
    int nbad = 0;
    logic [31:0] fa = '0, fe = '0;
    for (int idx = 0; idx <= NE; idx++) begin
      @(negedge clk);
      if (idx > 0) begin
        if (!rd_rsp_valid || rd_rsp_data !== mc[idx-1]) begin
          if (nbad == 0) begin fa = rd_rsp_data; fe = mc[idx-1]; end
          nbad++;
        end
      end
      if (idx < NE) begin
        rd_valid = 1'b1; rd_addr = 10'(idx);
      end else rd_valid = 1'b0;
    end
    check({req, " first mismatching C element"}, fa, fe);
    check({req, " mismatch count"}, 32'(nbad), 32'd0);
  endtask

  // Runs once; optionally injects a stray start, loads and a read request mid-run.
  task automatic run(input bit inject);
    int k = 0;
    int nr_ld = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    do begin
      @(posedge clk); k++;
      @(negedge clk);
      if (inject) begin
        start = (k == 100);
        if (k >= 200 && k < 204) begin
          ld_valid = 1'b1; ld_sel = 2'(k % 3); ld_addr = 10'(k); ld_data = $urandom;
          if (ld_ready) nr_ld++;
        end else ld_valid = 1'b0;
        if (k == 300) check("R8 rd_ready low while busy", 32'(rd_ready), 32'd0);
      end
    end while (!done && k < 3000);
    ld_valid = 1'b0; start = 1'b0;
    check("R6 start-to-done edges", 32'(k), 32'(EXP_LAT));
    check("R7 busy low with done", 32'(busy), 32'd0);
    @(negedge clk);
    check("R7 done one cycle", 32'(done), 32'd0);
    if (inject) begin
      check("R4 ld_ready low while busy", 32'(nr_ld), 32'd0);
      repeat (20) @(negedge clk);
      check("R5 no second run after stray start", {30'd0, busy, done}, 32'd0);
    end
  endtask

  initial begin
    if ($urandom(32'h5eed1234) == 0) ;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset state", {27'd0, busy, done, rd_rsp_valid, ld_ready, rd_ready}, 32'b00011);

    // random tiles, with mid-run disturbances (R2, R3, R4, R5, R11)
    for (int e = 0; e < NE; e++) begin ma[e] = 16'($urandom); mb[e] = 16'($urandom); mc[e] = $urandom; end
    load_tile(2'd0); load_tile(2'd1); load_tile(2'd2);
    read_all("R2 C load readback");
    run(1'b1);
    model_mac();
    read_all("R3 random tiles");

    // R9: chain with new A and B, C kept in place
    for (int e = 0; e < NE; e++) begin ma[e] = 16'($urandom); mb[e] = 16'($urandom); end
    load_tile(2'd0); load_tile(2'd1);
    run(1'b0);
    model_mac();
    read_all("R9 accumulate second run");

    // R10: select 3 touches nothing
    for (int t = 0; t < 8; t++) begin
      @(negedge clk);
      ld_valid = 1'b1; ld_sel = 2'd3; ld_addr = 10'(t * 131); ld_data = 32'h7fff_7fff;
    end
    @(negedge clk); ld_valid = 1'b0;
    read_all("R10 C after select 3");
    run(1'b0);
    model_mac();
    read_all("R10 A/B after select 3");

    // R3 wrap: all operands -32768, sum 2^35 wraps to zero
    for (int e = 0; e < NE; e++) begin ma[e] = 16'sh8000; mb[e] = 16'sh8000; mc[e] = $urandom; end
    load_tile(2'd0); load_tile(2'd1); load_tile(2'd2);
    run(1'b0);
    model_mac();
    read_all("R3 wrap corner");

    // R2/R11: identity A, C zero -> C equals B (upper data bits are junk)
    for (int e = 0; e < NE; e++) begin
      ma[e] = ((e / N) == (e % N)) ? 16'sd1 : 16'sd0; mb[e] = 16'($urandom); mc[e] = '0;
    end
    load_tile(2'd0); load_tile(2'd1); load_tile(2'd2);
    run(1'b0);
    model_mac();
    read_all("R11 identity A yields B");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: run did not finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule